// File: doc/BRIEF.md
# Serial Flash Command Frame Decoder

This block is the device-side front end of a serial flash that has one main array and two page buffers. It watches the chip-select, serial-clock and serial-data pins, and a frame starts when chip select falls. At that falling edge the block notes the level of the idle clock, which tells it whether the host clocks with a low or a high resting level. It then shifts in an opcode byte, most significant bit first, on rising clock edges. After the opcode it takes a three-byte address and skips the number of don't-care bytes that the opcode calls for.

When the header is complete, the block issues one decoded command. The command carries the opcode, the page address, the byte address, the buffer select and the clock polarity of the frame. After that, every whole byte of the data phase produces a one-cycle strobe. The array, the buffers and the program timer live elsewhere. They reach this block only through a busy flag and a busy-buffer indication, which the block uses to refuse commands that would collide with an operation in progress. An unknown opcode or a refused command raises an error flag, and the rest of the frame is ignored. An active-low hold-reset pin aborts the frame and keeps the decoder idle.

The pins are sampled in the system clock domain through a parameterised synchroniser, so the system clock must run several times faster than the serial clock.

Top module: `flash_frame_decoder`

## Requirements
- R1: After `rst` the outputs `cmd_valid_o`, `data_stb_o`, `err_o` and `miso_oe_o` are 0. The serial output stays in high impedance (`miso_oe_o` = 0). A frame is accepted only after a chip-select falling edge that is seen after reset, so a chip select already low when reset ends is ignored.
- R2: The level of `sclk_i` at the chip-select falling edge (0 = low idle, 1 = high idle) is reported as `cmd_cpol_o` with each command of that frame. Data is sampled on rising clock edges in both polarities.
- R3: While `hold_n` is low, any frame in progress is abandoned and no command or strobe is produced. After `hold_n` returns high, nothing is accepted until chip select has risen and fallen again.
- R4: The address is three bytes taken most significant first and forms a 24-bit field. The page address `cmd_page_o` is bits 17..9 of that field, the byte address `cmd_byte_o` is bits 8..0, and the buffer select `cmd_buf_o` is bit 23.
- R5: The byte address is reported as 0 for the page-only commands 50h, 53h, 58h, 60h, 81h, 83h and 88h. The page address is reported as 0 for the buffer commands 54h, D4h and 84h.
- R6: Opcodes 52h, 68h, D2h and E8h are followed by 4 don't-care bytes. The command is issued only after the fourth one, and none of these bytes is strobed.
- R7: Opcodes 54h and D4h are followed by exactly 1 don't-care byte before the command is issued.
- R8: Status opcodes 57h and D7h take no address. The command is issued right after the opcode byte, with page, byte and buffer fields equal to 0.
- R9: An opcode outside the set 50h, 52h, 53h, 54h, 57h, 58h, 60h, 68h, 81h, 82h, 83h, 84h, 88h, D2h, D4h, D7h, E8h sets `err_o`. No command or strobe follows until chip select rises, and `err_o` clears at the next chip-select falling edge.
- R10: If chip select rises during the address or don't-care bytes, no command is issued for that frame.
- R11: While `busy_i` is 1 when the header completes, any command that touches the main array (every accepted opcode except 54h, D4h, 84h, 57h and D7h) is refused. The refusal sets `err_o` and issues no command.
- R12: While busy, a buffer command (54h, D4h, 84h) whose buffer select equals `busy_buf_i` is refused in the same way. A buffer command aimed at the other buffer, and any status read, is accepted.
- R13: After a command is issued, each whole byte received before chip select rises pulses `data_stb_o` for one cycle with the byte on `data_o`. A partial byte at the end of the frame gives no strobe.
- R14: `miso_oe_o` is 1 only in the data phase of the read opcodes 52h, 54h, 57h, 68h, D2h, D4h, D7h and E8h. It is 0 in the data phase of write commands and outside frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_n | input | 1 | Active-low abort: holds the decoder idle |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| busy_i | input | 1 | An internal operation is in progress |
| busy_buf_i | input | 1 | Which buffer the ongoing operation uses |
| cmd_valid_o | output | 1 | One-cycle pulse: a decoded command is issued |
| cmd_op_o | output | 8 | Opcode of the command |
| cmd_page_o | output | 9 | Page address |
| cmd_byte_o | output | 9 | Byte address within page or buffer |
| cmd_buf_o | output | 1 | Buffer select |
| cmd_cpol_o | output | 1 | Idle clock level of the frame |
| data_stb_o | output | 1 | One-cycle pulse per data-phase byte |
| data_o | output | 8 | Data-phase byte |
| err_o | output | 1 | Unknown opcode or refused command in this frame |
| miso_oe_o | output | 1 | Serial output enable (0 = high impedance) |

## Verification
The bench builds the block with a two-stage synchroniser, four long and one short don't-care bytes, and a serial clock half-period of four system clocks. With these values the full don't-care counts are exercised, and frames can be driven in both clock polarities, including frames that end part-way through a header byte or a data byte. Busy gating is checked with both buffer selects, so that both a refusal and an acceptance of a buffer command under busy can be observed.

// File: rtl/ffd_pkg.sv
package ffd_pkg;

    localparam int FFD_PAGE_W     = 9;
    localparam int FFD_BYTE_W     = 9;
    localparam int FFD_ADDR_BYTES = 3;
    localparam int FFD_ADDR_W     = FFD_ADDR_BYTES * 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_DROP
    } state_t;

    typedef enum logic [1:0] {TGT_NONE, TGT_ARRAY, TGT_BUFFER} target_t;

    typedef enum logic [1:0] {DM_NONE, DM_SHORT, DM_LONG} dummy_t;

    typedef struct packed {
        logic    known;
        logic    has_addr;
        dummy_t  dcls;
        logic    rd;
        logic    use_page;
        logic    use_byte;
        target_t tgt;
    } op_info_t;

    typedef struct packed {
        logic [7:0]            op;
        logic [FFD_PAGE_W-1:0] page;
        logic [FFD_BYTE_W-1:0] bt;
        logic                  bsel;
        logic                  cpol;
    } cmd_t;

    function automatic op_info_t decode_op(input logic [7:0] op);
        op_info_t r;
        r = '{known: 1'b1, has_addr: 1'b1, dcls: DM_NONE, rd: 1'b0,
              use_page: 1'b1, use_byte: 1'b0, tgt: TGT_ARRAY};
        case (op)
            8'h50, 8'h53, 8'h58, 8'h60, 8'h81, 8'h83, 8'h88: ;
            8'h82: r.use_byte = 1'b1;
            8'h52, 8'hD2, 8'h68, 8'hE8: begin
                r.dcls     = DM_LONG;
                r.rd       = 1'b1;
                r.use_byte = 1'b1;
            end
            8'h54, 8'hD4: begin
                r.dcls     = DM_SHORT;
                r.rd       = 1'b1;
                r.use_page = 1'b0;
                r.use_byte = 1'b1;
                r.tgt      = TGT_BUFFER;
            end
            8'h84: begin
                r.use_page = 1'b0;
                r.use_byte = 1'b1;
                r.tgt      = TGT_BUFFER;
            end
            8'h57, 8'hD7: begin
                r.has_addr = 1'b0;
                r.rd       = 1'b1;
                r.use_page = 1'b0;
                r.tgt      = TGT_NONE;
            end
            default: r.known = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ffd_sync_edge.sv
module ffd_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic csn,
    input  logic sclk,
    input  logic mosi,
    output logic cs_fall,
    output logic cs_rise,
    output logic sclk_rise,
    output logic sclk_lvl,
    output logic mosi_s
);
    logic [2:0] pins_s;   // {csn, sclk, mosi} after synchronisation
    logic       csn_p, sclk_p;

    generate
        if (SYNC_STAGES == 0) begin : g_bypass
            assign pins_s = {csn, sclk, mosi};
        end else begin : g_chain
            logic [2:0] stage [SYNC_STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= 3'b000;
                end else begin
                    stage[0] <= {csn, sclk, mosi};
                    for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
                end
            end
            assign pins_s = stage[SYNC_STAGES-1];
        end
    endgenerate

    // Previous chip-select resets low so a select held low through reset is no edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            csn_p  <= 1'b0;
            sclk_p <= 1'b0;
        end else begin
            csn_p  <= pins_s[2];
            sclk_p <= pins_s[1];
        end
    end

    assign cs_fall   = csn_p & ~pins_s[2];
    assign cs_rise   = ~csn_p & pins_s[2];
    assign sclk_rise = ~sclk_p & pins_s[1] & ~pins_s[2];
    assign sclk_lvl  = pins_s[1];
    assign mosi_s    = pins_s[0];
endmodule

// File: rtl/ffd_shift.sv
module ffd_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       sample,
    input  logic       din,
    output logic       byte_done,
    output logic [7:0] byte_val
);
    logic [6:0] sh_q;
    logic [2:0] bit_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            bit_q <= '0;
        end else if (sample) begin
            sh_q  <= {sh_q[5:0], din};
            bit_q <= bit_q + 3'd1;
        end
    end

    assign byte_done = sample && !clr && (bit_q == 3'd7);
    assign byte_val  = {sh_q, din};
endmodule

// File: rtl/ffd_ctrl.sv
module ffd_ctrl
    import ffd_pkg::*;
#(
    parameter int LONG_DUMMY  = 4,
    parameter int SHORT_DUMMY = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_n,
    input  logic       cs_fall,
    input  logic       cs_rise,
    input  logic       sclk_lvl,
    input  logic       byte_done,
    input  logic [7:0] byte_val,
    input  logic       busy_i,
    input  logic       busy_buf_i,
    output logic       cmd_valid,
    output cmd_t       cmd,
    output logic       data_stb,
    output logic [7:0] data,
    output logic       err,
    output logic       rd_phase,
    output logic       active
);
    localparam int CNT_W = $clog2(LONG_DUMMY + FFD_ADDR_BYTES + 1);

    state_t                state_q;
    op_info_t              info_q, info_c;
    logic [7:0]            op_q, op_c;
    logic [FFD_ADDR_W-1:0] addr_q, addr_c;
    logic [CNT_W-1:0]      cnt_q, dummy_n;
    logic                  cpol_q;
    logic                  last_addr, last_dummy, go_issue, blocked;
    cmd_t                  issue_c;

    always_comb begin
        info_c = (state_q == ST_OPC) ? decode_op(byte_val) : info_q;
        op_c   = (state_q == ST_OPC) ? byte_val : op_q;
        addr_c = (state_q == ST_ADDR) ? {addr_q[FFD_ADDR_W-9:0], byte_val} : addr_q;
        case (info_c.dcls)
            DM_LONG:  dummy_n = CNT_W'(LONG_DUMMY);
            DM_SHORT: dummy_n = CNT_W'(SHORT_DUMMY);
            default:  dummy_n = '0;
        endcase
        last_addr  = (cnt_q == CNT_W'(FFD_ADDR_BYTES - 1));
        last_dummy = ((cnt_q + CNT_W'(1)) == dummy_n);
        go_issue   = byte_done &&
                     ((state_q == ST_OPC && info_c.known && !info_c.has_addr) ||
                      (state_q == ST_ADDR && last_addr && dummy_n == '0) ||
                      (state_q == ST_DUMMY && last_dummy));
        blocked    = busy_i &&
                     ((info_c.tgt == TGT_ARRAY) ||
                      (info_c.tgt == TGT_BUFFER && addr_c[FFD_ADDR_W-1] == busy_buf_i));
        issue_c.op   = op_c;
        issue_c.page = info_c.use_page ? addr_c[FFD_BYTE_W +: FFD_PAGE_W] : '0;
        issue_c.bt   = info_c.use_byte ? addr_c[FFD_BYTE_W-1:0] : '0;
        issue_c.bsel = info_c.has_addr ? addr_c[FFD_ADDR_W-1] : 1'b0;
        issue_c.cpol = cpol_q;
    end

    always_ff @(posedge clk) begin
        cmd_valid <= 1'b0;
        data_stb  <= 1'b0;
        if (rst || !hold_n) begin
            state_q <= ST_IDLE;
            info_q  <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
            cpol_q  <= 1'b1;
            cmd     <= '0;
            data    <= '0;
            err     <= 1'b0;
        end else if (cs_fall) begin
            state_q <= ST_OPC;
            cpol_q  <= sclk_lvl;
            addr_q  <= '0;
            cnt_q   <= '0;
            err     <= 1'b0;
        end else if (cs_rise) begin
            state_q <= ST_IDLE;
        end else if (byte_done) begin
            if (go_issue) begin
                if (blocked) begin
                    err     <= 1'b1;
                    state_q <= ST_DROP;
                end else begin
                    cmd_valid <= 1'b1;
                    cmd       <= issue_c;
                    state_q   <= ST_DATA;
                end
                info_q <= info_c;
                op_q   <= op_c;
                addr_q <= addr_c;
            end else begin
                case (state_q)
                    ST_OPC: begin
                        info_q <= info_c;
                        op_q   <= op_c;
                        cnt_q  <= '0;
                        if (!info_c.known) begin
                            err     <= 1'b1;
                            state_q <= ST_DROP;
                        end else begin
                            state_q <= ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= addr_c;
                        if (last_addr) begin
                            cnt_q   <= '0;
                            state_q <= ST_DUMMY;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_DUMMY: cnt_q <= cnt_q + CNT_W'(1);
                    ST_DATA: begin
                        data_stb <= 1'b1;
                        data     <= byte_val;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_phase = (state_q == ST_DATA) && info_q.rd;
    assign active   = (state_q != ST_IDLE) && (state_q != ST_DROP);
endmodule

// File: rtl/flash_frame_decoder.sv
module flash_frame_decoder
    import ffd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LONG_DUMMY  = 4,
    parameter int SHORT_DUMMY = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hold_n,
    input  logic                  csn_i,
    input  logic                  sclk_i,
    input  logic                  mosi_i,
    input  logic                  busy_i,
    input  logic                  busy_buf_i,
    output logic                  cmd_valid_o,
    output logic [7:0]            cmd_op_o,
    output logic [FFD_PAGE_W-1:0] cmd_page_o,
    output logic [FFD_BYTE_W-1:0] cmd_byte_o,
    output logic                  cmd_buf_o,
    output logic                  cmd_cpol_o,
    output logic                  data_stb_o,
    output logic [7:0]            data_o,
    output logic                  err_o,
    output logic                  miso_oe_o
);
    logic       cs_fall, cs_rise, sclk_rise, sclk_lvl, mosi_s;
    logic       byte_done, active;
    logic [7:0] byte_val;
    cmd_t       cmd;

    ffd_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .csn(csn_i), .sclk(sclk_i), .mosi(mosi_i),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_rise(sclk_rise),
        .sclk_lvl(sclk_lvl), .mosi_s(mosi_s)
    );

    ffd_shift u_shift (
        .clk(clk), .rst(rst), .clr(cs_fall | ~active), .sample(sclk_rise),
        .din(mosi_s), .byte_done(byte_done), .byte_val(byte_val)
    );

    ffd_ctrl #(.LONG_DUMMY(LONG_DUMMY), .SHORT_DUMMY(SHORT_DUMMY)) u_ctrl (
        .clk(clk), .rst(rst), .hold_n(hold_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_lvl(sclk_lvl), .byte_done(byte_done), .byte_val(byte_val),
        .busy_i(busy_i), .busy_buf_i(busy_buf_i), .cmd_valid(cmd_valid_o), .cmd(cmd),
        .data_stb(data_stb_o), .data(data_o), .err(err_o), .rd_phase(miso_oe_o),
        .active(active)
    );

    assign cmd_op_o   = cmd.op;
    assign cmd_page_o = cmd.page;
    assign cmd_byte_o = cmd.bt;
    assign cmd_buf_o  = cmd.bsel;
    assign cmd_cpol_o = cmd.cpol;
endmodule

// File: rtl/ffd_checker.sv
module ffd_checker (
    input logic       clk,
    input logic       rst,
    input logic       hold_n,
    input logic       csn_i,
    input logic       sclk_i,
    input logic       mosi_i,
    input logic       busy_i,
    input logic       busy_buf_i,
    input logic       cmd_valid_o,
    input logic [7:0] cmd_op_o,
    input logic [8:0] cmd_page_o,
    input logic [8:0] cmd_byte_o,
    input logic       cmd_buf_o,
    input logic       cmd_cpol_o,
    input logic       data_stb_o,
    input logic [7:0] data_o,
    input logic       err_o,
    input logic       miso_oe_o
);
    logic buf_op;
    assign buf_op = (cmd_op_o == 8'h54) || (cmd_op_o == 8'hD4) || (cmd_op_o == 8'h84);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cmd_valid_o && !data_stb_o && !err_o && !miso_oe_o);

    a_r3_hold_silences: assert property (@(posedge clk) disable iff (rst)
        !hold_n |=> !cmd_valid_o && !data_stb_o && !miso_oe_o);

    a_r9_err_blocks_output: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !cmd_valid_o && !data_stb_o && !miso_oe_o);

    a_r13_strobe_not_with_cmd: assert property (@(posedge clk) disable iff (rst)
        data_stb_o |-> !cmd_valid_o);

    a_r5_buffer_page_zero: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o && buf_op |-> cmd_page_o == 9'd0);

    a_r11_busy_array_refused: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o && $past(busy_i) |->
            buf_op || cmd_op_o == 8'h57 || cmd_op_o == 8'hD7);

    a_r12_busy_other_buffer: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o && $past(busy_i) && buf_op |-> cmd_buf_o != $past(busy_buf_i));
endmodule

bind flash_frame_decoder ffd_checker u_ffd_checker (.*);

// File: tb/flash_frame_decoder_bench.sv
module flash_frame_decoder_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, hold_n = 1'b1, csn = 1'b0, sclk = 1'b1, mosi = 1'b0;
    logic busy = 1'b0, busy_buf = 1'b0;
    logic       cmd_valid_o, cmd_buf_o, cmd_cpol_o, data_stb_o, err_o, miso_oe_o;
    logic [7:0] cmd_op_o, data_o;
    logic [8:0] cmd_page_o, cmd_byte_o;

    flash_frame_decoder #(.SYNC_STAGES(2), .LONG_DUMMY(4), .SHORT_DUMMY(1)) u_flash_frame_decoder (
        .clk(clk), .rst(rst), .hold_n(hold_n), .csn_i(csn), .sclk_i(sclk), .mosi_i(mosi),
        .busy_i(busy), .busy_buf_i(busy_buf), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
        .cmd_page_o(cmd_page_o), .cmd_byte_o(cmd_byte_o), .cmd_buf_o(cmd_buf_o),
        .cmd_cpol_o(cmd_cpol_o), .data_stb_o(data_stb_o), .data_o(data_o), .err_o(err_o),
        .miso_oe_o(miso_oe_o)
    );

    typedef struct {
        bit          is_cmd;
        logic [27:0] fields;   // {op, page, byte, buf, cpol} or data byte
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0, fails = 0;
    bit   done = 0;
    logic cur_cpol = 1'b1;
    localparam int H = 4;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (!rst && !done) begin
            if (cmd_valid_o) begin
                if (q.size() == 0 || !q[0].is_cmd)
                    chk(0, "R9", "unexpected command", int'(cmd_op_o), 0);
                else begin
                    e = q.pop_front();
                    chk({cmd_op_o, cmd_page_o, cmd_byte_o, cmd_buf_o, cmd_cpol_o} == e.fields,
                        e.req, "command",
                        int'({cmd_op_o, cmd_page_o, cmd_byte_o, cmd_buf_o, cmd_cpol_o}),
                        int'(e.fields));
                end
            end
            if (data_stb_o) begin
                if (q.size() == 0 || q[0].is_cmd)
                    chk(0, "R13", "unexpected strobe", int'(data_o), 0);
                else begin
                    e = q.pop_front();
                    chk({20'd0, data_o} == e.fields, e.req, "strobe data",
                        int'(data_o), int'(e.fields));
                end
            end
        end
    end

    // Expected command built from the requirements (R4, R5, R8)
    task automatic exp_cmd(input logic [7:0] op, input logic [23:0] a, input string req);
        exp_t e;
        logic [8:0] pg, bt;
        logic       bs;
        bit page_only, buf_cmd, status;
        page_only = op inside {8'h50, 8'h53, 8'h58, 8'h60, 8'h81, 8'h83, 8'h88};
        buf_cmd   = op inside {8'h54, 8'hD4, 8'h84};
        status    = op inside {8'h57, 8'hD7};
        pg = (buf_cmd || status) ? 9'd0 : a[17:9];
        bt = (page_only || status) ? 9'd0 : a[8:0];
        bs = status ? 1'b0 : a[23];
        e.is_cmd = 1;
        e.fields = {op, pg, bt, bs, cur_cpol};
        e.req    = req;
        q.push_back(e);
    endtask

    task automatic exp_stb(input logic [7:0] d, input string req);
        exp_t e;
        e.is_cmd = 0;
        e.fields = {20'd0, d};
        e.req    = req;
        q.push_back(e);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_start(input logic pol);
        sclk = pol;
        wait_clk(6);
        csn      = 1'b0;
        cur_cpol = pol;
        wait_clk(6);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sclk = 1'b0;
            mosi = b[i];
            wait_clk(H);
            sclk = 1'b1;
            wait_clk(H);
        end
        if (!cur_cpol) sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic send_addr(input logic [23:0] a);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
    endtask

    task automatic frame_end();
        wait_clk(H);
        csn  = 1'b1;
        sclk = cur_cpol;
        wait_clk(10);
    endtask

    task automatic drained(input string req);
        wait_clk(8);
        chk(q.size() == 0, req, "pending expected items", q.size(), 0);
        q.delete();
    endtask

    initial begin
        // R1: reset state
        wait_clk(5);
        chk(!cmd_valid_o && !data_stb_o, "R1", "no pulses in reset",
            {cmd_valid_o, data_stb_o}, 0);
        chk(!miso_oe_o, "R1", "output high impedance in reset", miso_oe_o, 0);
        chk(!err_o, "R1", "error clear in reset", err_o, 0);

        // R1: chip select low across reset release must not start a frame
        rst = 1'b0;
        wait_clk(4);
        send_byte(8'hD7);
        wait_clk(8);
        chk(!miso_oe_o, "R1", "no data phase without fresh select", miso_oe_o, 0);
        drained("R1");
        frame_end();

        // R4, R2: mode 3 program-through-buffer with data bytes (R13, R14)
        frame_start(1'b1);
        exp_cmd(8'h82, 24'h812345, "R4");
        exp_stb(8'hA5, "R13");
        exp_stb(8'h5A, "R13");
        send_byte(8'h82);
        send_addr(24'h812345);
        send_byte(8'hA5);
        wait_clk(6);
        chk(!miso_oe_o, "R14", "no output enable for write", miso_oe_o, 0);
        send_byte(8'h5A);
        send_bits(8'hFF, 5);          // partial byte, no strobe (R13)
        frame_end();
        drained("R13");

        // R6, R2: mode 0 page read with 4 dummy bytes
        frame_start(1'b0);
        exp_cmd(8'h52, 24'h03FE01, "R6");
        exp_stb(8'h11, "R13");
        send_byte(8'h52);
        send_addr(24'h03FE01);
        for (int i = 0; i < 3; i++) send_byte(8'hC3);
        wait_clk(8);
        chk(q.size() == 2, "R6", "no command before 4th dummy byte", q.size(), 2);
        send_byte(8'hC3);
        wait_clk(8);
        chk(miso_oe_o, "R14", "output enable in read data phase", miso_oe_o, 1);
        send_byte(8'h11);
        frame_end();
        chk(!miso_oe_o, "R14", "output off after frame", miso_oe_o, 0);
        drained("R6");

        // R10: frame cut in dummy phase and in address phase
        frame_start(1'b1);
        send_byte(8'hE8);
        send_addr(24'h000200);
        send_byte(8'h00);
        send_byte(8'h00);
        frame_end();
        drained("R10");
        frame_start(1'b0);
        send_byte(8'h53);
        send_byte(8'h01);
        frame_end();
        drained("R10");

        // R7, R5: buffer read with one dummy byte, buffer 1
        frame_start(1'b1);
        exp_cmd(8'hD4, 24'h9FF0AB, "R7");
        exp_stb(8'h3C, "R13");
        send_byte(8'hD4);
        send_addr(24'h9FF0AB);
        wait_clk(8);
        chk(q.size() == 2, "R7", "no command before dummy byte", q.size(), 2);
        send_byte(8'h77);
        send_byte(8'h3C);
        frame_end();
        drained("R7");

        // R5: page erase drops byte field
        frame_start(1'b0);
        exp_cmd(8'h81, 24'h01FFFF, "R5");
        send_byte(8'h81);
        send_addr(24'h01FFFF);
        frame_end();
        drained("R5");

        // R8: status read, command right after opcode
        frame_start(1'b1);
        exp_cmd(8'hD7, 24'h0, "R8");
        send_byte(8'hD7);
        wait_clk(8);
        chk(q.size() == 0, "R8", "status command after opcode", q.size(), 0);
        chk(miso_oe_o, "R8", "output enable for status", miso_oe_o, 1);
        frame_end();
        drained("R8");

        // R9: unknown opcode
        frame_start(1'b1);
        send_byte(8'h55);
        wait_clk(8);
        chk(err_o, "R9", "error after unknown opcode", err_o, 1);
        send_addr(24'h123456);
        send_byte(8'h99);
        wait_clk(4);
        chk(err_o, "R9", "error held in frame", err_o, 1);
        frame_end();
        drained("R9");
        frame_start(1'b0);
        wait_clk(4);
        chk(!err_o, "R9", "error cleared by new select", err_o, 0);
        exp_cmd(8'h57, 24'h0, "R9");
        send_byte(8'h57);
        frame_end();
        drained("R9");

        // R3: hold-reset mid-frame
        frame_start(1'b1);
        send_byte(8'h82);
        send_byte(8'h00);
        hold_n = 1'b0;
        wait_clk(6);
        hold_n = 1'b1;
        send_byte(8'h12);
        send_byte(8'h34);
        send_byte(8'h56);
        wait_clk(8);
        chk(!err_o && !miso_oe_o, "R3", "idle after hold", {err_o, miso_oe_o}, 0);
        frame_end();
        drained("R3");
        frame_start(1'b1);
        exp_cmd(8'hD7, 24'h0, "R3");
        send_byte(8'hD7);
        frame_end();
        drained("R3");

        // R11, R12: busy gating, buffer 0 busy
        busy = 1'b1;
        busy_buf = 1'b0;
        frame_start(1'b1);
        send_byte(8'h83);
        send_addr(24'h000400);
        wait_clk(8);
        chk(err_o, "R11", "array command refused", err_o, 1);
        frame_end();
        drained("R11");
        frame_start(1'b1);
        exp_cmd(8'h84, 24'h800010, "R12");
        exp_stb(8'hEE, "R12");
        send_byte(8'h84);
        send_addr(24'h800010);
        send_byte(8'hEE);
        frame_end();
        drained("R12");
        frame_start(1'b0);
        send_byte(8'h84);
        send_addr(24'h000010);
        send_byte(8'hEE);
        wait_clk(4);
        chk(err_o, "R12", "busy buffer write refused", err_o, 1);
        frame_end();
        drained("R12");
        frame_start(1'b0);
        exp_cmd(8'h57, 24'h0, "R12");
        send_byte(8'h57);
        frame_end();
        drained("R12");
        busy = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule